// File: doc/BRIEF.md
# Delayed-Branch Instruction Sequencer

This block is the sequencing core of a small 32-bit processor. It holds two program counters. One is the address being fetched now. The other is the address that follows it. Because the following address is fixed one step ahead, the instruction placed right after a branch or jump always runs. On each step the block raises one instruction fetch request, marked cached or uncached by address. It then takes the returned word, together with an error flag, and executes a reduced instruction set. That set is an add with immediate, a register add, a branch-if-equal, an absolute jump, a word load, a word store and a multiply whose latency is a parameter.

A load or store does not reach memory in the step that decodes it. The access is held in a register and presented on the data port during the next step, while the following instruction is fetched and executed. A load result that returns in that same cycle is forwarded to the instruction that needs it. A multiply longer than one cycle raises a busy indication and withholds fetch until the product is written back. Interrupt lines are sampled into a register every cycle.

Instruction word: bits 31:28 opcode, 27:24 destination register, 23:20 first source, 19:16 second source, 15:0 immediate. Opcodes are 0 add-immediate, 1 add, 2 branch-if-equal, 3 jump, 4 load, 5 store and 6 multiply. Any other opcode does nothing.

Top module: `dbseq_core`

## Requirements
- R1: While reset is asserted, the fetch address equals RESET_PC and fetch valid is high. Data request, busy and fetch_fault are low, and irq_seen is zero.
- R2: Opcode 0 writes rs + sign-extended imm into rd. Opcode 1 writes rs + rt into rd. Opcodes 7 to 15 change no register.
- R3: The instruction after a branch or jump always executes. When rs == rt, opcode 2 redirects to the branch address + 4 × sign-extended imm. Opcode 3 redirects to 4 × zero-extended imm. In any other case the sequence continues at +4.
- R4: Opcode 6 writes the low 32 bits of rs × rt into rd after MUL_LAT cycles. When MUL_LAT > 1, busy is high and fetch valid is low for MUL_LAT−1 cycles after the multiply is accepted. The next instruction sees the product.
- R5: A load (opcode 4) or store (opcode 5) at address rs + sign-extended imm appears on the data request in the cycle after it is accepted. In that same cycle the next instruction is fetched. A store writes rt (data_req_write = 1). A returning load value is forwarded to the very next instruction.
- R6: fetch_req_uncached is 1 exactly when the fetch address is at or above UNC_BASE.
- R7: An instruction returned with fetch_rsp_err = 1 executes as a no-op, and fetch_fault pulses high for one cycle afterwards.
- R8: While a fetch response or an outstanding data response is absent, no instruction is accepted and the fetch address and pending data request hold.
- R9: irq_seen equals the value irq_lines had at the previous clock edge.
- R10: Register 0 reads as zero, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req_valid | output | 1 | Instruction fetch request is valid |
| fetch_req_uncached | output | 1 | Fetch targets the uncached region |
| fetch_req_addr | output | 32 | Current instruction address |
| fetch_rsp_valid | input | 1 | Instruction word is available this cycle |
| fetch_rsp_err | input | 1 | Fetch ended in a bus error |
| fetch_rsp_instr | input | 32 | Returned instruction word |
| data_req_valid | output | 1 | Registered data access is pending |
| data_req_write | output | 1 | Pending access is a store |
| data_req_addr | output | 32 | Pending access address |
| data_req_wdata | output | 32 | Store data |
| data_rsp_valid | input | 1 | Data access completes this cycle |
| data_rsp_rdata | input | 32 | Load data |
| busy | output | 1 | Multi-cycle multiply in progress |
| fetch_fault | output | 1 | One-cycle pulse after a faulted fetch |
| irq_lines | input | NIRQ | Interrupt lines |
| irq_seen | output | NIRQ | Registered interrupt sample |

## Verification
A corrupted current or next PC shows on the fetch address at the very next accepted step. A taken branch misses by one slot and that shows as a wrong address two fetches later. A wrong pending access shows on the data request one cycle after the load or store is accepted. Register-file errors stay hidden until a store exposes them, so each directed program ends by storing the registers it changed, and a lost forward or a dropped multiply result shows as a wrong store word a few cycles later.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;
   localparam int XLEN = 32;

   typedef enum logic [3:0] {
      OP_ADDI = 4'h0,
      OP_ADD  = 4'h1,
      OP_BEQ  = 4'h2,
      OP_JMP  = 4'h3,
      OP_LD   = 4'h4,
      OP_ST   = 4'h5,
      OP_MUL  = 4'h6
   } op_e;

   typedef struct packed {
      logic            is_alu;
      logic            use_imm;
      logic            is_beq;
      logic            is_jmp;
      logic            is_ld;
      logic            is_st;
      logic            is_mul;
      logic [3:0]      rd;
      logic [3:0]      rs;
      logic [3:0]      rt;
      logic [XLEN-1:0] imm_s;
      logic [XLEN-1:0] imm_z;
   } dec_t;
endpackage

// File: rtl/dbseq_decode.sv
module dbseq_decode
   import dbseq_pkg::*;
(
   input  logic [XLEN-1:0] instr,
   input  logic            fault,
   output dec_t            dec
);
   always_comb begin
      dec       = '0;
      dec.rd    = instr[27:24];
      dec.rs    = instr[23:20];
      dec.rt    = instr[19:16];
      dec.imm_s = {{(XLEN-16){instr[15]}}, instr[15:0]};
      dec.imm_z = {{(XLEN-16){1'b0}}, instr[15:0]};
      if (!fault) begin
         case (instr[31:28])
            OP_ADDI: begin dec.is_alu = 1'b1; dec.use_imm = 1'b1; end
            OP_ADD:  dec.is_alu = 1'b1;
            OP_BEQ:  dec.is_beq = 1'b1;
            OP_JMP:  dec.is_jmp = 1'b1;
            OP_LD:   dec.is_ld  = 1'b1;
            OP_ST:   dec.is_st  = 1'b1;
            OP_MUL:  dec.is_mul = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dbseq_regfile.sv
module dbseq_regfile #(
   parameter int NREG = 16,
   parameter int XLEN = 32,
   parameter int AW   = $clog2(NREG)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra_a,
   input  logic [AW-1:0]   ra_b,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b,
   input  logic            we_p,
   input  logic [AW-1:0]   wa_p,
   input  logic [XLEN-1:0] wd_p,
   input  logic            we_s,
   input  logic [AW-1:0]   wa_s,
   input  logic [XLEN-1:0] wd_s
);
   logic [XLEN-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= '0;
            else if (we_p && wa_p == AW'(g))   q <= wd_p;
            else if (we_s && wa_s == AW'(g))   q <= wd_s;
         end
         assign regs[g] = q;
      end
   end

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];
endmodule

// File: rtl/dbseq_mul.sv
module dbseq_mul #(
   parameter int XLEN = 32,
   parameter int LAT  = 3,
   parameter int TW   = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [TW-1:0]   tag,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] prod,
   output logic [TW-1:0]   tag_out
);
   if (LAT == 1) begin : g_comb
      assign busy    = 1'b0;
      assign done    = start;
      assign prod    = a * b;
      assign tag_out = tag;
   end else begin : g_seq
      localparam int CW = $clog2(LAT) + 1;
      logic [XLEN-1:0] opa, opb;
      logic [CW-1:0]   cnt;
      logic            run;
      logic [TW-1:0]   tg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            opa <= '0;
            opb <= '0;
            tg  <= '0;
         end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
            opa <= a;
            opb <= b;
            tg  <= tag;
         end else if (run) begin
            if (cnt == CW'(LAT - 2)) run <= 1'b0;
            else                     cnt <= cnt + 1'b1;
         end
      end

      assign busy    = run;
      assign done    = run && (cnt == CW'(LAT - 2));
      assign prod    = opa * opb;
      assign tag_out = tg;
   end
endmodule

// File: rtl/dbseq_core.sv
module dbseq_core
   import dbseq_pkg::*;
#(
   parameter int              NREG     = 16,
   parameter int              MUL_LAT  = 3,
   parameter int              NIRQ     = 6,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter logic [XLEN-1:0] UNC_BASE = 32'h8000_0000
)(
   input  logic            clk,
   input  logic            rst_n,
   output logic            fetch_req_valid,
   output logic            fetch_req_uncached,
   output logic [XLEN-1:0] fetch_req_addr,
   input  logic            fetch_rsp_valid,
   input  logic            fetch_rsp_err,
   input  logic [XLEN-1:0] fetch_rsp_instr,
   output logic            data_req_valid,
   output logic            data_req_write,
   output logic [XLEN-1:0] data_req_addr,
   output logic [XLEN-1:0] data_req_wdata,
   input  logic            data_rsp_valid,
   input  logic [XLEN-1:0] data_rsp_rdata,
   output logic            busy,
   output logic            fetch_fault,
   input  logic [NIRQ-1:0] irq_lines,
   output logic [NIRQ-1:0] irq_seen
);
   localparam int              AW   = $clog2(NREG);
   localparam logic [XLEN-1:0] WSTEP = XLEN'(4);

   if (NREG < 2 || NREG > 16 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two from 2 to 16");
   end
   if (MUL_LAT < 1) begin : g_bad_lat
      $error("MUL_LAT must be at least 1");
   end
   if (NIRQ < 1) begin : g_bad_irq
      $error("NIRQ must be at least 1");
   end

   logic [XLEN-1:0] pc_q, npc_q, nxt_npc;
   logic            dm_valid_q, dm_write_q;
   logic [XLEN-1:0] dm_addr_q, dm_wdata_q;
   logic [AW-1:0]   dm_rd_q;
   dec_t            dec;
   logic            step, adv, mem_done, ld_ret, taken;
   logic            mul_busy, mul_done;
   logic [AW-1:0]   rs_a, rt_a, rd_a, mul_rd;
   logic [XLEN-1:0] rf_s, rf_t, op_s, op_t, alu_res, mul_res;
   logic            wp_en;
   logic [AW-1:0]   wp_addr;
   logic [XLEN-1:0] wp_data;

   dbseq_decode u_dec (
      .instr (fetch_rsp_instr),
      .fault (fetch_rsp_err),
      .dec   (dec)
   );

   assign rs_a = dec.rs[AW-1:0];
   assign rt_a = dec.rt[AW-1:0];
   assign rd_a = dec.rd[AW-1:0];

   // Acceptance needs a fetched word, a resolved previous access and no multiply in flight
   assign mem_done = dm_valid_q && data_rsp_valid;
   assign ld_ret   = mem_done && !dm_write_q;
   assign step     = !mul_busy && fetch_rsp_valid && (!dm_valid_q || data_rsp_valid);

   // Forward a returning load into the instruction decoded alongside it
   assign op_s = (ld_ret && dm_rd_q == rs_a && rs_a != '0) ? data_rsp_rdata : rf_s;
   assign op_t = (ld_ret && dm_rd_q == rt_a && rt_a != '0) ? data_rsp_rdata : rf_t;

   assign alu_res = op_s + (dec.use_imm ? dec.imm_s : op_t);
   assign taken   = dec.is_beq && (op_s == op_t);

   always_comb begin
      if (step && taken)           nxt_npc = pc_q + (dec.imm_s << 2);
      else if (step && dec.is_jmp) nxt_npc = dec.imm_z << 2;
      else                         nxt_npc = npc_q + WSTEP;
   end

   assign adv     = (step && !dec.is_mul) || mul_done;
   assign wp_en   = (step && dec.is_alu) || mul_done;
   assign wp_addr = mul_done ? mul_rd  : rd_a;
   assign wp_data = mul_done ? mul_res : alu_res;

   dbseq_regfile #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_rf (
      .clk  (clk),
      .rst_n(rst_n),
      .ra_a (rs_a),
      .ra_b (rt_a),
      .rd_a (rf_s),
      .rd_b (rf_t),
      .we_p (wp_en),
      .wa_p (wp_addr),
      .wd_p (wp_data),
      .we_s (ld_ret),
      .wa_s (dm_rd_q),
      .wd_s (data_rsp_rdata)
   );

   dbseq_mul #(.XLEN(XLEN), .LAT(MUL_LAT), .TW(AW)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (step && dec.is_mul),
      .a      (op_s),
      .b      (op_t),
      .tag    (rd_a),
      .busy   (mul_busy),
      .done   (mul_done),
      .prod   (mul_res),
      .tag_out(mul_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         npc_q <= RESET_PC + WSTEP;
      end else if (adv) begin
         pc_q  <= npc_q;
         npc_q <= nxt_npc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dm_valid_q <= 1'b0;
         dm_write_q <= 1'b0;
         dm_addr_q  <= '0;
         dm_wdata_q <= '0;
         dm_rd_q    <= '0;
      end else if (step && (dec.is_ld || dec.is_st)) begin
         dm_valid_q <= 1'b1;
         dm_write_q <= dec.is_st;
         dm_addr_q  <= op_s + dec.imm_s;
         dm_wdata_q <= op_t;
         dm_rd_q    <= rd_a;
      end else if (mem_done) begin
         dm_valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_fault <= 1'b0;
         irq_seen    <= '0;
      end else begin
         fetch_fault <= step && fetch_rsp_err;
         irq_seen    <= irq_lines;
      end
   end

   assign fetch_req_valid    = !mul_busy;
   assign fetch_req_addr     = pc_q;
   assign fetch_req_uncached = (pc_q >= UNC_BASE);
   assign data_req_valid     = dm_valid_q;
   assign data_req_write     = dm_write_q;
   assign data_req_addr      = dm_addr_q;
   assign data_req_wdata     = dm_wdata_q;
   assign busy               = mul_busy;
endmodule

// File: rtl/dbseq_core_chk.sv
module dbseq_core_chk #(
   parameter int MUL_LAT = 3,
   parameter int NIRQ    = 6
)(
   input logic            clk,
   input logic            rst_n,
   input logic            fetch_req_valid,
   input logic [31:0]     fetch_req_addr,
   input logic            fetch_rsp_valid,
   input logic            fetch_rsp_err,
   input logic            data_req_valid,
   input logic [31:0]     data_req_addr,
   input logic            data_rsp_valid,
   input logic            busy,
   input logic            fetch_fault,
   input logic [NIRQ-1:0] irq_lines,
   input logic [NIRQ-1:0] irq_seen
);
   int blen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    blen <= 0;
      else if (busy) blen <= blen + 1;
      else           blen <= 0;
   end

   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (blen < MUL_LAT - 1));

   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(fetch_req_valid && fetch_rsp_valid));

   // R5
   mem_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_req_valid) |-> $past(fetch_req_valid && fetch_rsp_valid));

   // R8
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_valid && !fetch_rsp_valid) |=> $stable(fetch_req_addr));

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_req_valid && !data_rsp_valid) |=>
         (data_req_valid && $stable(data_req_addr) && $stable(fetch_req_addr)));

   // R7
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_fault |-> $past(fetch_rsp_err && fetch_rsp_valid));

   // R9
   irq_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq_seen == $past(irq_lines)));
endmodule

bind dbseq_core dbseq_core_chk #(.MUL_LAT(MUL_LAT), .NIRQ(NIRQ)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_req_valid(fetch_req_valid),
   .fetch_req_addr (fetch_req_addr),
   .fetch_rsp_valid(fetch_rsp_valid),
   .fetch_rsp_err  (fetch_rsp_err),
   .data_req_valid (data_req_valid),
   .data_req_addr  (data_req_addr),
   .data_rsp_valid (data_rsp_valid),
   .busy           (busy),
   .fetch_fault    (fetch_fault),
   .irq_lines      (irq_lines),
   .irq_seen       (irq_seen)
);

// File: tb/tb_dbseq_core.sv
module tb_dbseq_core;
   localparam int MLAT = 3;
   localparam int NI   = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_ok = 1'b1;
   logic        data_ready = 1'b1;
   logic [NI-1:0] irq_lines = '0;

   logic        fetch_req_valid, fetch_req_uncached, fetch_rsp_err;
   logic [31:0] fetch_req_addr, fetch_rsp_instr;
   logic        data_req_valid, data_req_write;
   logic [31:0] data_req_addr, data_req_wdata, data_rsp_rdata;
   logic        busy, fetch_fault;
   logic [NI-1:0] irq_seen;

   logic [31:0] imem [0:1023];
   logic        ierr [0:1023];
   logic [31:0] dmem [0:255];

   assign fetch_rsp_instr = imem[fetch_req_addr[11:2]];
   assign fetch_rsp_err   = ierr[fetch_req_addr[11:2]];
   assign data_rsp_rdata  = dmem[data_req_addr[9:2]];

   dbseq_core #(
      .NREG(16), .MUL_LAT(MLAT), .NIRQ(NI),
      .RESET_PC(32'h0), .UNC_BASE(32'h400)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req_valid(fetch_req_valid), .fetch_req_uncached(fetch_req_uncached),
      .fetch_req_addr(fetch_req_addr), .fetch_rsp_valid(fetch_ok),
      .fetch_rsp_err(fetch_rsp_err), .fetch_rsp_instr(fetch_rsp_instr),
      .data_req_valid(data_req_valid), .data_req_write(data_req_write),
      .data_req_addr(data_req_addr), .data_req_wdata(data_req_wdata),
      .data_rsp_valid(data_ready), .data_rsp_rdata(data_rsp_rdata),
      .busy(busy), .fetch_fault(fetch_fault),
      .irq_lines(irq_lines), .irq_seen(irq_seen)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // Logs of completed stores and accepted fetches
   logic [31:0] st_addr [0:15];
   logic [31:0] st_data [0:15];
   int          st_n;
   logic [31:0] fa [0:31];
   logic        fu [0:31];
   int          fn;

   always @(posedge clk) begin
      if (!rst_n) begin
         st_n <= 0;
         fn   <= 0;
      end else begin
         if (data_req_valid && data_ready && data_req_write && st_n < 16) begin
            st_addr[st_n] <= data_req_addr;
            st_data[st_n] <= data_req_wdata;
            st_n <= st_n + 1;
         end
         if (fetch_req_valid && fetch_ok && (!data_req_valid || data_ready) && fn < 32) begin
            fa[fn] <= fetch_req_addr;
            fu[fn] <= fetch_req_uncached;
            fn <= fn + 1;
         end
      end
   end

   int          busy_cyc, busy_fetch, fault_cnt;
   bit          dseen;
   logic [31:0] dseen_faddr, dseen_daddr;

   always @(negedge clk) begin
      if (!rst_n) begin
         busy_cyc = 0; busy_fetch = 0; fault_cnt = 0; dseen = 1'b0;
         dseen_faddr = '0; dseen_daddr = '0;
      end else begin
         if (busy) busy_cyc++;
         if (busy && fetch_req_valid) busy_fetch++;
         if (fetch_fault) fault_cnt++;
         if (data_req_valid && !dseen) begin
            dseen = 1'b1;
            dseen_faddr = fetch_req_addr;
            dseen_daddr = data_req_addr;
         end
      end
   end

   function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                       input logic [3:0] rs, input logic [3:0] rt,
                                       input logic [15:0] imm);
      return {op, rd, rs, rt, imm};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) begin imem[i] = '0; ierr[i] = 1'b0; end
      for (int i = 0; i < 256; i++) dmem[i] = '0;
   endtask

   task automatic put(input int addr, input logic [31:0] w);
      imem[addr >> 2] = w;
   endtask

   task automatic restart();
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      clear_mem();
      @(negedge clk);
      rst_n = 1'b0;
      irq_lines = 6'b111111;
      tick(2);
      chk("R1", "fetch addr in reset", fetch_req_addr, 32'h0);
      chk("R1", "fetch valid/data valid/busy/fault", {28'h0, fetch_req_valid, data_req_valid, busy, fetch_fault},
          32'h8);
      chk("R1", "irq_seen in reset", {26'h0, irq_seen}, 32'h0);
      irq_lines = '0;
   endtask

   task automatic t_alu();
      clear_mem();
      put(32'h00, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd5));
      put(32'h04, enc(4'h0, 4'd2, 4'd0, 4'd0, 16'hFFFD));
      put(32'h08, enc(4'h1, 4'd3, 4'd1, 4'd2, 16'h0));
      put(32'h0C, enc(4'h5, 4'd0, 4'd0, 4'd3, 16'h100));
      put(32'h10, enc(4'h0, 4'd0, 4'd0, 4'd0, 16'd5));
      put(32'h14, enc(4'h5, 4'd0, 4'd0, 4'd0, 16'h104));
      put(32'h18, enc(4'h9, 4'd1, 4'd1, 4'd1, 16'h7));
      put(32'h1C, enc(4'h5, 4'd0, 4'd0, 4'd1, 16'h108));
      put(32'h20, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h8));
      restart();
      tick(30);
      chk("R2", "store count", st_n, 3);
      chk("R2", "add result address", st_addr[0], 32'h100);
      chk("R2", "5 + (-3)", st_data[0], 32'd2);
      chk("R10", "r0 after write", st_data[1], 32'd0);
      chk("R2", "undefined opcode leaves r1", st_data[2], 32'd5);
   endtask

   task automatic t_branch();
      logic [31:0] exp_f [0:9];
      clear_mem();
      put(32'h00, enc(4'h2, 4'd0, 4'd0, 4'd0, 16'd4));
      put(32'h04, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd1));
      put(32'h08, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd99));
      put(32'h0C, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd77));
      put(32'h10, enc(4'h5, 4'd0, 4'd0, 4'd1, 16'h100));
      put(32'h14, enc(4'h2, 4'd0, 4'd1, 4'd0, 16'd8));
      put(32'h18, enc(4'h0, 4'd2, 4'd0, 4'd0, 16'd3));
      put(32'h1C, enc(4'h0, 4'd2, 4'd2, 4'd0, 16'd4));
      put(32'h20, enc(4'h5, 4'd0, 4'd0, 4'd2, 16'h104));
      put(32'h24, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h100));
      put(32'h28, enc(4'h0, 4'd3, 4'd0, 4'd0, 16'd5));
      put(32'h2C, enc(4'h0, 4'd3, 4'd0, 4'd0, 16'd66));
      put(32'h400, enc(4'h5, 4'd0, 4'd0, 4'd3, 16'h108));
      put(32'h404, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h101));
      exp_f = '{32'h00, 32'h04, 32'h10, 32'h14, 32'h18, 32'h1C, 32'h20, 32'h24, 32'h28, 32'h400};
      restart();
      tick(30);
      for (int i = 0; i < 10; i++) chk("R3", $sformatf("fetch order #%0d", i), fa[i], exp_f[i]);
      chk("R3", "taken branch delay slot value", st_data[0], 32'd1);
      chk("R3", "not-taken branch path value", st_data[1], 32'd7);
      chk("R3", "jump delay slot value", st_data[2], 32'd5);
      chk("R6", "cached flag below base", {31'h0, fu[8]}, 32'd0);
      chk("R6", "uncached flag at base", {31'h0, fu[9]}, 32'd1);
   endtask

   task automatic t_mul();
      clear_mem();
      put(32'h00, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd6));
      put(32'h04, enc(4'h0, 4'd2, 4'd0, 4'd0, 16'd7));
      put(32'h08, enc(4'h6, 4'd3, 4'd1, 4'd2, 16'h0));
      put(32'h0C, enc(4'h1, 4'd4, 4'd3, 4'd1, 16'h0));
      put(32'h10, enc(4'h5, 4'd0, 4'd0, 4'd3, 16'h100));
      put(32'h14, enc(4'h5, 4'd0, 4'd0, 4'd4, 16'h104));
      put(32'h18, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h6));
      restart();
      tick(30);
      chk("R4", "busy cycles", busy_cyc, MLAT - 1);
      chk("R4", "fetch while busy", busy_fetch, 0);
      chk("R4", "product", st_data[0], 32'd42);
      chk("R4", "product used next", st_data[1], 32'd48);
      chk("R4", "fetch after multiply", fa[3], 32'h0C);
   endtask

   task automatic t_load();
      clear_mem();
      dmem[16] = 32'h1234;
      put(32'h00, enc(4'h4, 4'd1, 4'd0, 4'd0, 16'h40));
      put(32'h04, enc(4'h1, 4'd2, 4'd1, 4'd1, 16'h0));
      put(32'h08, enc(4'h5, 4'd0, 4'd0, 4'd2, 16'h104));
      put(32'h0C, enc(4'h5, 4'd0, 4'd0, 4'd1, 16'h108));
      put(32'h10, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h4));
      restart();
      tick(30);
      chk("R5", "load address", dseen_daddr, 32'h40);
      chk("R5", "fetch alongside data access", dseen_faddr, 32'h04);
      chk("R5", "forwarded load sum", st_data[0], 32'h2468);
      chk("R5", "loaded register", st_data[1], 32'h1234);
   endtask

   task automatic t_dstall();
      clear_mem();
      dmem[16] = 32'h0055;
      put(32'h00, enc(4'h4, 4'd1, 4'd0, 4'd0, 16'h40));
      put(32'h04, enc(4'h1, 4'd2, 4'd1, 4'd1, 16'h0));
      put(32'h08, enc(4'h5, 4'd0, 4'd0, 4'd2, 16'h104));
      put(32'h0C, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h3));
      data_ready = 1'b0;
      restart();
      tick(6);
      chk("R8", "fetch addr held during data stall", fetch_req_addr, 32'h04);
      chk("R8", "pending load held", {data_req_valid, data_req_addr[30:0]}, 32'h8000_0040);
      chk("R8", "accepted fetches during stall", fn, 1);
      data_ready = 1'b1;
      tick(20);
      chk("R8", "result after stall", st_data[0], 32'h00AA);
   endtask

   task automatic t_fstall();
      clear_mem();
      put(32'h00, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd9));
      put(32'h04, enc(4'h5, 4'd0, 4'd0, 4'd1, 16'h100));
      put(32'h08, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h2));
      fetch_ok = 1'b0;
      restart();
      tick(5);
      chk("R8", "fetch addr held without response", fetch_req_addr, 32'h0);
      chk("R8", "nothing accepted", fn + st_n, 0);
      fetch_ok = 1'b1;
      tick(20);
      chk("R8", "result after fetch stall", st_data[0], 32'd9);
   endtask

   task automatic t_fault();
      clear_mem();
      put(32'h00, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd3));
      put(32'h04, enc(4'h0, 4'd1, 4'd0, 4'd0, 16'd50));
      ierr[1] = 1'b1;
      put(32'h08, enc(4'h5, 4'd0, 4'd0, 4'd1, 16'h100));
      put(32'h0C, enc(4'h3, 4'd0, 4'd0, 4'd0, 16'h3));
      restart();
      tick(20);
      chk("R7", "faulted instruction skipped", st_data[0], 32'd3);
      chk("R7", "fault pulse cycles", fault_cnt, 1);
      chk("R7", "sequence continues past fault", fa[2], 32'h08);
   endtask

   task automatic t_irq();
      @(negedge clk);
      irq_lines = 6'b101101;
      @(negedge clk);
      chk("R9", "irq sample A", {26'h0, irq_seen}, 32'h2D);
      irq_lines = 6'b010010;
      chk("R9", "irq not yet updated", {26'h0, irq_seen}, 32'h2D);
      @(negedge clk);
      chk("R9", "irq sample B", {26'h0, irq_seen}, 32'h12);
   endtask

   initial begin
      t_reset();
      t_alu();
      t_branch();
      t_mul();
      t_load();
      t_dstall();
      t_fstall();
      t_fault();
      t_irq();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule